// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives a four-line, twenty-column character display through its 8-bit parallel write bus. The bus is write-only. The read/write pin stays low and the display's busy flag is never read. Every transfer is therefore followed by a fixed, parameterised wait. After reset the block runs a scripted power-up sequence and then accepts requests on a valid/ready port.

A request can be one of four kinds:
- a raw command byte;
- a character code;
- a "go to position" that turns a linear cell number into a set-address command;
- a blank-screen sequence that turns the display off, clears it and turns it back on.

Linear positions follow the order in which the panel fills when written as a stream: the first line, then the third, then the second, then the fourth. Positions past the last cell wrap back to the start.

Each transfer has three phases:
1. Register-select and the data byte are set up.
2. The enable strobe is raised for a fixed number of cycles.
3. The bus is held after the strobe falls, and then the post-transfer wait runs.

All delays are cycle counts, given as parameters.

Top module: `charlcd_writer`

## Requirements
- R1: While reset is high and right after it, `lcd_en` is 0, `req_ready` is 0 and `lcd_rs`/`lcd_d` are 0. The first enable pulse rises exactly POWERUP_CYC+1+SETUP_CYC cycles after reset is released.
- R2: The power-up script sends, with register-select 0, exactly these bytes in this order: 0x30, 0x30, 0x30, 0x38, 0x08, 0x01, 0x06, 0x0C, 0x80.
- R3: Within the power-up script, the time from one enable fall to the next enable rise is HOLD_CYC+wait+1+SETUP_CYC. The wait is LONG_CYC after the first 0x30, SHORT_CYC after the second and third 0x30, CLEAR_CYC after 0x01, and GAP_CYC after every other byte.
- R4: On every transfer, `lcd_rs`/`lcd_d` are stable for at least SETUP_CYC cycles before `lcd_en` rises. `lcd_en` stays high for exactly PULSE_CYC cycles. The bus does not change while `lcd_en` is high, nor for at least HOLD_CYC cycles after it falls.
- R5: `lcd_rw` is 0 at all times.
- R6: `req_ready` is 1 only when no script or transfer is active. A request is taken on a cycle where `req_valid` and `req_ready` are both 1. Each single-transfer request produces exactly one enable pulse. `req_ready` returns exactly HOLD_CYC+wait cycles after that pulse falls.
- R7: `req_kind` 2'b00 sends `req_data` as a command (register-select 0). `req_kind` 2'b01 sends it as a character (register-select 1). In both cases the byte appears on `lcd_d[7:0]` with bit 7 on `lcd_d[7]`.
- R8: A command of 0x01, 0x02 or 0x03 (clear or return-home) is followed by CLEAR_CYC wait cycles. Every other command, and every character, is followed by GAP_CYC.
- R9: `req_kind` 2'b10 treats `req_data` as a linear cell number and reduces it modulo 80 to p. It sends command 0x80 | a, where a = p for p < 40 and a = p + 24 otherwise. This puts cells 0-19 on line 1, 20-39 on line 3, 40-59 on line 2 and 60-79 on line 4. The wait after it is GAP_CYC.
- R10: `req_kind` 2'b11 sends 0x08, 0x01, 0x0C in that order with register-select 0, followed by waits of GAP_CYC, CLEAR_CYC and GAP_CYC respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 00 command, 01 character, 10 go to position, 11 blank-screen sequence |
| req_data | input | 8 | Command byte, character code or linear position |
| lcd_rs | output | 1 | Register select: 0 command, 1 character data |
| lcd_rw | output | 1 | Read/write select, held low |
| lcd_en | output | 1 | Enable strobe |
| lcd_d | output | 8 | Data bus, bit 7 on lcd_d[7] |

## Verification
The bench sweeps every byte value as a command, every byte value as a character and every byte value as a position. A mapper that skips the 1-3-2-4 line interleave, or that fails to wrap at cell 80, sends the wrong set-address byte at cells 20, 40, 60 and 80. A decoder that gives only 0x01 the long wait, or misses 0x03, returns ready too early on a return-home.

The script is checked byte by byte and gap by gap. A swapped long and short wait, a missing third 0x30, or a blank-screen sequence in the wrong order shows up as a wrong byte or a wrong interval. Off-by-one counters show up as a pulse width, a setup window or a ready delay that misses its exact cycle count.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

  typedef enum logic [1:0] {
    REQ_CMD   = 2'b00,
    REQ_CHAR  = 2'b01,
    REQ_GOTO  = 2'b10,
    REQ_BLANK = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    WT_GAP   = 2'd0,
    WT_CLEAR = 2'd1,
    WT_LONG  = 2'd2,
    WT_SHORT = 2'd3
  } wait_sel_e;

  localparam int SCRIPT_AW     = 4;
  localparam int INIT_LAST     = 8;
  localparam int BLANK_FIRST   = 9;
  localparam int BLANK_LAST    = 11;
  localparam logic [7:0] SET_ADDR = 8'h80;

endpackage

// File: rtl/charlcd_script.sv
module charlcd_script
  import charlcd_pkg::*;
(
  input  logic [SCRIPT_AW-1:0] idx,
  output logic [7:0]           cmd_byte,
  output wait_sel_e            cmd_wait
);

  always_comb begin
    unique case (idx)
      4'd0:    begin cmd_byte = 8'h30; cmd_wait = WT_LONG;  end
      4'd1:    begin cmd_byte = 8'h30; cmd_wait = WT_SHORT; end
      4'd2:    begin cmd_byte = 8'h30; cmd_wait = WT_SHORT; end
      4'd3:    begin cmd_byte = 8'h38; cmd_wait = WT_GAP;   end
      4'd4:    begin cmd_byte = 8'h08; cmd_wait = WT_GAP;   end
      4'd5:    begin cmd_byte = 8'h01; cmd_wait = WT_CLEAR; end
      4'd6:    begin cmd_byte = 8'h06; cmd_wait = WT_GAP;   end
      4'd7:    begin cmd_byte = 8'h0C; cmd_wait = WT_GAP;   end
      4'd8:    begin cmd_byte = SET_ADDR; cmd_wait = WT_GAP; end
      4'd9:    begin cmd_byte = 8'h08; cmd_wait = WT_GAP;   end
      4'd10:   begin cmd_byte = 8'h01; cmd_wait = WT_CLEAR; end
      4'd11:   begin cmd_byte = 8'h0C; cmd_wait = WT_GAP;   end
      default: begin cmd_byte = 8'h00; cmd_wait = WT_GAP;   end
    endcase
  end

endmodule

// File: rtl/charlcd_posmap.sv
module charlcd_posmap #(
  parameter int COLS = 20,
  parameter int ROWS = 4
) (
  input  logic [7:0] pos,
  output logic [6:0] addr
);

  localparam int CELLS      = COLS * ROWS;
  localparam int PAIR_CELLS = 2 * COLS;
  localparam int LINE2_BASE = 'h40;
  localparam int WRAPS      = 256 / CELLS + 1;

  always_comb begin
    int p;
    p = int'(pos);
    for (int i = 0; i < WRAPS; i++) begin
      if (p >= CELLS) p = p - CELLS;
    end
    if (p < PAIR_CELLS) addr = 7'(p);
    else                addr = 7'(LINE2_BASE + p - PAIR_CELLS);
  end

endmodule

// File: rtl/charlcd_strobe.sv
module charlcd_strobe #(
  parameter int CNT_W     = 32,
  parameter int SETUP_CYC = 10,
  parameter int PULSE_CYC = 113,
  parameter int HOLD_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rs_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] wait_i,
  output logic             lcd_rs,
  output logic             lcd_en,
  output logic [7:0]       lcd_d,
  output logic             done
);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_HOLD, ST_WAIT} st_e;

  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_CYC - 1);

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wait_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign done     = (st == ST_WAIT) && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      wait_q <= '0;
      lcd_en <= 1'b0;
      lcd_rs <= 1'b0;
      lcd_d  <= 8'h00;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          lcd_rs <= rs_i;
          lcd_d  <= data_i;
          wait_q <= wait_i;
          cnt    <= SETUP_M1;
          st     <= ST_SETUP;
        end
        ST_SETUP: if (cnt_zero) begin
          lcd_en <= 1'b1;
          cnt    <= PULSE_M1;
          st     <= ST_HIGH;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt_zero) begin
          lcd_en <= 1'b0;
          cnt    <= HOLD_M1;
          st     <= ST_HOLD;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt_zero) begin
          cnt <= wait_q - 1'b1;
          st  <= ST_WAIT;
        end else cnt <= cnt - 1'b1;
        ST_WAIT: if (cnt_zero) st <= ST_IDLE;
                 else          cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/charlcd_writer.sv
module charlcd_writer
  import charlcd_pkg::*;
#(
  parameter int COLS        = 20,
  parameter int ROWS        = 4,
  parameter int CNT_W       = 32,
  parameter int POWERUP_CYC = 10_000_000,
  parameter int LONG_CYC    = 1_025_000,
  parameter int SHORT_CYC   = 25_000,
  parameter int GAP_CYC     = 12_500,
  parameter int CLEAR_CYC   = 500_000,
  parameter int SETUP_CYC   = 10,
  parameter int PULSE_CYC   = 113,
  parameter int HOLD_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_d
);

  typedef enum logic [1:0] {SQ_PWR, SQ_ISSUE, SQ_BUSY, SQ_IDLE} sq_e;

  localparam logic [CNT_W-1:0] PWR_M1 = CNT_W'(POWERUP_CYC - 1);

  sq_e                  sq;
  logic [CNT_W-1:0]     pwr_cnt;
  logic [SCRIPT_AW-1:0] idx, last_idx;
  logic                 scripted;
  logic                 cur_rs;
  logic [7:0]           cur_d;
  wait_sel_e            cur_w;

  logic [7:0]       rom_byte;
  wait_sel_e        rom_w;
  logic [6:0]       goto_addr;
  logic             st_rs, st_done;
  logic [7:0]       st_d;
  wait_sel_e        st_wsel;
  logic [CNT_W-1:0] st_wait;
  req_kind_e        kind;
  logic             cmd_is_clear;

  charlcd_script u_script (
    .idx      (idx),
    .cmd_byte (rom_byte),
    .cmd_wait (rom_w)
  );

  charlcd_posmap #(.COLS(COLS), .ROWS(ROWS)) u_posmap (
    .pos  (req_data),
    .addr (goto_addr)
  );

  assign kind         = req_kind_e'(req_kind);
  assign cmd_is_clear = (req_data[7:1] == 7'd0 && req_data[0]) || (req_data[7:1] == 7'd1);

  assign st_rs   = scripted ? 1'b0     : cur_rs;
  assign st_d    = scripted ? rom_byte : cur_d;
  assign st_wsel = scripted ? rom_w    : cur_w;

  always_comb begin
    unique case (st_wsel)
      WT_CLEAR: st_wait = CNT_W'(CLEAR_CYC);
      WT_LONG:  st_wait = CNT_W'(LONG_CYC);
      WT_SHORT: st_wait = CNT_W'(SHORT_CYC);
      default:  st_wait = CNT_W'(GAP_CYC);
    endcase
  end

  charlcd_strobe #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .start  (sq == SQ_ISSUE),
    .rs_i   (st_rs),
    .data_i (st_d),
    .wait_i (st_wait),
    .lcd_rs (lcd_rs),
    .lcd_en (lcd_en),
    .lcd_d  (lcd_d),
    .done   (st_done)
  );

  assign lcd_rw    = 1'b0;
  assign req_ready = (sq == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq       <= SQ_PWR;
      pwr_cnt  <= PWR_M1;
      idx      <= '0;
      last_idx <= '0;
      scripted <= 1'b0;
      cur_rs   <= 1'b0;
      cur_d    <= 8'h00;
      cur_w    <= WT_GAP;
    end else begin
      unique case (sq)
        SQ_PWR: if (pwr_cnt == '0) begin
          idx      <= '0;
          last_idx <= SCRIPT_AW'(INIT_LAST);
          scripted <= 1'b1;
          sq       <= SQ_ISSUE;
        end else pwr_cnt <= pwr_cnt - 1'b1;
        SQ_ISSUE: sq <= SQ_BUSY;
        SQ_BUSY: if (st_done) begin
          if (scripted && idx != last_idx) begin
            idx <= idx + 1'b1;
            sq  <= SQ_ISSUE;
          end else begin
            scripted <= 1'b0;
            sq       <= SQ_IDLE;
          end
        end
        SQ_IDLE: if (req_valid) begin
          sq <= SQ_ISSUE;
          unique case (kind)
            REQ_BLANK: begin
              scripted <= 1'b1;
              idx      <= SCRIPT_AW'(BLANK_FIRST);
              last_idx <= SCRIPT_AW'(BLANK_LAST);
            end
            REQ_CHAR: begin
              cur_rs <= 1'b1;
              cur_d  <= req_data;
              cur_w  <= WT_GAP;
            end
            REQ_GOTO: begin
              cur_rs <= 1'b0;
              cur_d  <= SET_ADDR | {1'b0, goto_addr};
              cur_w  <= WT_GAP;
            end
            default: begin
              cur_rs <= 1'b0;
              cur_d  <= req_data;
              cur_w  <= cmd_is_clear ? WT_CLEAR : WT_GAP;
            end
          endcase
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/charlcd_writer_chk.sv
module charlcd_writer_chk #(
  parameter int PULSE_CYC = 113
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic [7:0] lcd_d
);

  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)         hi_cnt <= '0;
    else if (lcd_en) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> hi_cnt == 32'(PULSE_CYC)); // R4
  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> $stable({lcd_rs, lcd_d})); // R4
  AST_BUS_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> $stable({lcd_rs, lcd_d})); // R4
  AST_BUS_HELD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |=> $stable({lcd_rs, lcd_d})); // R4
  AST_NOT_READY_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> !req_ready); // R6
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R6

endmodule

bind charlcd_writer charlcd_writer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .lcd_rs    (lcd_rs),
  .lcd_en    (lcd_en),
  .lcd_d     (lcd_d)
);

// File: tb/charlcd_writer_tb.sv
module charlcd_writer_tb;

  localparam int PWR = 100, LONGW = 40, SHORTW = 10, GAP = 5, CLR = 20;
  localparam int SU = 2, PW = 3, HD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_data = 8'h00;
  logic       req_ready, lcd_rs, lcd_rw, lcd_en;
  logic [7:0] lcd_d;

  always #2 clk = ~clk;

  charlcd_writer #(
    .POWERUP_CYC(PWR), .LONG_CYC(LONGW), .SHORT_CYC(SHORTW), .GAP_CYC(GAP),
    .CLEAR_CYC(CLR), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_d(lcd_d)
  );

  int checks = 0, fails = 0;
  int cyc = 0, log_n = 0, t_chg = 0, t_fall = 0, t_rdy = 0, c_rel = 0;
  bit seen_fall = 0, rw_bad = 0, prev_en = 0, prev_rdy = 0;
  logic [8:0] prev_bus = 9'h0, mon_bus;
  int l_rise [16];
  int l_fall [16];
  logic [7:0] l_d [16];
  logic l_rs [16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (lcd_rw) rw_bad = 1;
    if (rst) begin
      prev_en = 0; prev_rdy = 0; prev_bus = 9'h0; seen_fall = 0; t_chg = cyc;
    end else begin
      mon_bus = {lcd_rs, lcd_d};
      if (mon_bus != prev_bus) begin
        if (lcd_en) check(0, "R4 bus moved with E high", int'(mon_bus), int'(prev_bus));
        if (seen_fall) check(cyc - t_fall >= HD, "R4 hold after E fall", cyc - t_fall, HD);
        t_chg = cyc;
      end
      if (lcd_en && !prev_en) begin
        l_rs[log_n % 16] = lcd_rs;
        l_d[log_n % 16] = lcd_d;
        l_rise[log_n % 16] = cyc;
        check(cyc - t_chg >= SU, "R4 setup before E rise", cyc - t_chg, SU);
        log_n++;
      end
      if (!lcd_en && prev_en) begin
        check(cyc - l_rise[(log_n - 1) % 16] == PW, "R4 E pulse width",
              cyc - l_rise[(log_n - 1) % 16], PW);
        l_fall[(log_n - 1) % 16] = cyc;
        t_fall = cyc;
        seen_fall = 1;
      end
      if (req_ready && !prev_rdy) t_rdy = cyc;
      prev_en = lcd_en; prev_rdy = req_ready; prev_bus = mon_bus;
    end
  end

  task automatic wait_ready();
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d, output int n0);
    wait_ready();
    n0 = log_n;
    req_valid = 1'b1; req_kind = k; req_data = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_ready();
  endtask

  task automatic single(input logic [1:0] k, input logic [7:0] d,
                        input logic ers, input logic [7:0] ed, input int w, input string tag);
    int n0, e;
    send(k, d, n0);
    e = n0 % 16;
    check(log_n == n0 + 1, {tag, " one pulse per request (R6)"}, log_n - n0, 1);
    check(l_rs[e] == ers && l_d[e] == ed, {tag, " bus value"}, int'({l_rs[e], l_d[e]}), int'({ers, ed}));
    check(t_rdy - l_fall[e] == HD + w, {tag, " ready delay (R6)"}, t_rdy - l_fall[e], HD + w);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] init_b [9];
    int init_w [9];
    int n0;
    init_b = '{8'h30, 8'h30, 8'h30, 8'h38, 8'h08, 8'h01, 8'h06, 8'h0C, 8'h80};
    init_w = '{LONGW, SHORTW, SHORTW, GAP, GAP, CLR, GAP, GAP, GAP};

    repeat (4) @(negedge clk);
    #1;
    check(lcd_en == 0 && req_ready == 0 && lcd_rw == 0, "R1 reset outputs",
          int'({lcd_en, req_ready, lcd_rw}), 0);
    check({lcd_rs, lcd_d} == 9'h0, "R1 reset bus", int'({lcd_rs, lcd_d}), 0);
    rst = 1'b0;
    c_rel = cyc;

    wait_ready();
    check(log_n == 9, "R2 init transfer count", log_n, 9);
    check(l_rise[0] - c_rel == PWR + 1 + SU, "R1 power-up delay", l_rise[0] - c_rel, PWR + 1 + SU);
    for (int i = 0; i < 9; i++) begin
      check(l_rs[i] == 1'b0 && l_d[i] == init_b[i], "R2 init byte",
            int'({l_rs[i], l_d[i]}), int'(init_b[i]));
      if (i > 0)
        check(l_rise[i] - l_fall[i-1] == HD + init_w[i-1] + 1 + SU, "R3 init gap",
              l_rise[i] - l_fall[i-1], HD + init_w[i-1] + 1 + SU);
    end
    check(t_rdy - l_fall[8] == HD + GAP, "R3 ready after init (R6)", t_rdy - l_fall[8], HD + GAP);

    for (int c = 0; c < 256; c++) begin
      int w;
      w = (c >= 1 && c <= 3) ? CLR : GAP;
      single(2'b00, 8'(c), 1'b0, 8'(c), w, "R7 R8 command");
    end

    for (int c = 0; c < 256; c++)
      single(2'b01, 8'(c), 1'b1, 8'(c), GAP, "R7 character");

    for (int p = 0; p < 256; p++) begin
      int q, a;
      q = p % 80;
      a = (q < 40) ? q : q + 24;
      single(2'b10, 8'(p), 1'b0, 8'(8'h80 | a), GAP, "R9 position map");
    end

    send(2'b11, 8'h00, n0);
    check(log_n == n0 + 3, "R10 blank transfer count", log_n - n0, 3);
    check(l_d[n0 % 16] == 8'h08 && l_d[(n0+1) % 16] == 8'h01 && l_d[(n0+2) % 16] == 8'h0C,
          "R10 blank order", int'({l_d[n0 % 16], l_d[(n0+1) % 16], l_d[(n0+2) % 16]}), 'h08010C);
    check(!l_rs[n0 % 16] && !l_rs[(n0+1) % 16] && !l_rs[(n0+2) % 16], "R10 blank rs", 1, 0);
    check(l_rise[(n0+1) % 16] - l_fall[n0 % 16] == HD + GAP + 1 + SU, "R10 gap after off",
          l_rise[(n0+1) % 16] - l_fall[n0 % 16], HD + GAP + 1 + SU);
    check(l_rise[(n0+2) % 16] - l_fall[(n0+1) % 16] == HD + CLR + 1 + SU, "R10 gap after clear",
          l_rise[(n0+2) % 16] - l_fall[(n0+1) % 16], HD + CLR + 1 + SU);
    check(t_rdy - l_fall[(n0+2) % 16] == HD + GAP, "R10 ready after on",
          t_rdy - l_fall[(n0+2) % 16], HD + GAP);

    check(!rw_bad, "R5 rw never high", int'(rw_bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule